// File: doc/BRIEF.md
# DQ Bus Turnaround Scheduler

This block sits between a request queue and the command pins of a synchronous DRAM. It decides the cycle on which each read or write command may leave, so that the data lines never carry read data from the memory and write data from the controller at the same time. Each read occupies the bus for a window that opens a programmable CAS latency after the command and lasts one burst. Each write drives its first beat in the same cycle as its command. The scheduler tracks both kinds of traffic cycle by cycle and holds back any command that would collide.

Two policies decide what a write does when it meets read traffic that is still in flight. In the waiting policy the write is held until the read window has drained and one idle cycle has passed. In the cutting policy the scheduler raises the data mask at once on the read beats that are still due. The write then goes out on the next cycle, and every later beat of those reads stays masked. A read-valid strobe marks only the read beats that really arrive. The output enable covers exactly the beats of each write.

Requests use a valid/ready handshake with a type bit. Write data is taken from a stream input on every cycle in which the output enable is high. Bank timing and refresh are handled elsewhere. The configuration inputs are only changed while no traffic is in flight.

Top module: `dq_turn_sched`

## Requirements
- R1: The CAS latency input takes the value 2 or 3. The burst code maps 0, 1, 2 and 3 to 1, 2, 4 and 8 beats. A read whose command issues in cycle t raises rd_valid in cycles t+CL through t+CL+BL-1, provided none of those beats is masked.
- R2: A write whose command issues in cycle t raises dq_oe in cycles t through t+BL-1 and in no other cycle. In each of those cycles dq_out equals wr_data.
- R3: While reset is held and just after it, cmd_issue, dq_oe, dqm and rd_valid are low and req_ready is high.
- R4: dq_oe and rd_valid are never high in the same cycle.
- R5: When cutting is disabled, a write requested behind a read issues two cycles after the last read beat. This leaves exactly one idle bus cycle between them.
- R6: A read is not accepted while its first beat would come earlier than two cycles after the last beat of a pending write.
- R7: When cutting is enabled and a write is requested while unmasked read beats are still due, dqm is high in that cycle and on every later beat of those reads. rd_valid stays low on the masked beats, and the write issues on the next cycle.
- R8: Two reads of the same burst length can be sent back to back. The second is accepted BL cycles after the first, so rd_valid is continuous across both bursts.
- R9: Two writes can be sent back to back. The second is accepted BL cycles after the first, so dq_oe is continuous across both bursts.
- R10: cmd_issue is high only in a cycle where req_valid and req_ready are both high. cmd_write follows req_write in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_cas_lat | input | 2 | CAS latency, 2 or 3 |
| cfg_burst | input | 2 | Burst length code: 0 gives 1 beat, 1 gives 2, 2 gives 4, 3 gives 8 |
| cfg_cut_read | input | 1 | 1 selects the cutting policy (mask the read beats and send the write), 0 selects the waiting policy |
| req_valid | input | 1 | A request is offered |
| req_write | input | 1 | 1 for a write request, 0 for a read request |
| req_ready | output | 1 | The offered request is taken in this cycle |
| wr_data | input | DW | Write data stream, consumed while dq_oe is high |
| cmd_issue | output | 1 | A command is sent in this cycle |
| cmd_write | output | 1 | The command sent in this cycle is a write |
| dq_oe | output | 1 | The controller drives the data lines |
| dq_out | output | DW | Data driven onto the data lines |
| dqm | output | 1 | Data mask applied to the read beat of this cycle |
| rd_valid | output | 1 | An unmasked read beat is on the data lines |

## Verification
A write request can meet read beats that are still in flight. On a wrong design this makes the write enable and a read beat land in one cycle, or the mask and the write enable line up in the wrong cycle. The directed tests provoke this in three ways: a read followed at once by a write, with each policy, and a write followed at once by a read. The cutting case sends the write request in the middle of an 8-beat read. Every cycle is logged at the falling edge. The logs must show no cycle with both dq_oe and rd_valid high. They must also show the idle cycle where the requirement asks for it, and under the cutting policy the mask on exactly the read beats from the request cycle onward.

// File: rtl/dq_sched_pkg.sv
`timescale 1ns/1ps
package dq_sched_pkg;

  typedef logic [1:0] burst_code_t;

  // Beats in one burst for a burst-length code: 1, 2, 4 or 8.
  function automatic int unsigned beats_of(input burst_code_t code);
    return 32'd1 << code;
  endfunction

  // Bring the configured CAS latency into the range the block supports.
  function automatic logic [1:0] clamp_cl(input logic [1:0] v, input int lo, input int hi);
    if (int'(v) < lo) return 2'(lo);
    if (int'(v) > hi) return 2'(hi);
    return v;
  endfunction

endpackage

// File: rtl/dq_rd_occupancy.sv
`timescale 1ns/1ps
// Cycle map of read data on the bus. Bit i of the map means a read beat
// lands i cycles from now. A second map marks the beats to be masked.
module dq_rd_occupancy
  import dq_sched_pkg::*;
#(
  parameter int MAX_CL = 3,
  parameter int MAX_BL = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  cl,
  input  burst_code_t bl,
  input  logic        rd_issue,
  input  logic        kill,
  output logic        beat_now,
  output logic        beat_masked,
  output logic        live_any,
  output logic        rd_clash
);
  localparam int MAP_W = MAX_CL + MAX_BL;

  logic [MAP_W-1:0] rd_map, msk_map;
  logic [MAP_W-1:0] new_now, new_next;

  // Bits start .. start+beats-1 set, others clear.
  function automatic logic [MAP_W-1:0] span(input int start, input int unsigned beats);
    logic [MAP_W-1:0] m;
    m = '0;
    for (int i = 0; i < MAP_W; i++)
      if (i >= start && i < start + int'(beats)) m[i] = 1'b1;
    return m;
  endfunction

  // The window a read issued now would occupy, seen from this cycle and
  // from the next one.
  assign new_now  = span(int'(cl), beats_of(bl));
  assign new_next = span(int'(cl) - 1, beats_of(bl));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_map  <= '0;
      msk_map <= '0;
    end else begin
      rd_map  <= (rd_map >> 1) | (rd_issue ? new_next : '0);
      msk_map <= (msk_map | (kill ? rd_map : '0)) >> 1;
    end
  end

  assign beat_now    = rd_map[0];
  assign beat_masked = rd_map[0] & (msk_map[0] | kill);
  assign live_any    = |(rd_map & ~msk_map);
  assign rd_clash    = |(rd_map & new_now);

endmodule

// File: rtl/dq_wr_beats.sv
`timescale 1ns/1ps
// Counts the write beats still to be driven after the command cycle.
module dq_wr_beats
  import dq_sched_pkg::*;
#(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  burst_code_t      bl,
  input  logic             wr_issue,
  output logic [CNT_W-1:0] wr_left,
  output logic             wr_busy
);
  always_ff @(posedge clk) begin
    if (!rst_n)
      wr_left <= '0;
    else if (wr_issue)
      wr_left <= CNT_W'(beats_of(bl) - 1);
    else if (wr_left != '0)
      wr_left <= wr_left - 1'b1;
  end

  assign wr_busy = (wr_left != '0);

endmodule

// File: rtl/dq_issue_ctrl.sv
`timescale 1ns/1ps
// Decides whether the offered request may issue in this cycle.
module dq_issue_ctrl #(
  parameter int CNT_W = 3
) (
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             cut_read,
  input  logic [1:0]       cl,
  input  logic [CNT_W-1:0] wr_left,
  input  logic             live_any,
  input  logic             rd_clash,
  input  logic             last_rd_beat,
  output logic             req_ready,
  output logic             rd_issue,
  output logic             wr_issue,
  output logic             kill
);
  logic wr_idle, wr_ok, rd_ok;

  always_comb begin
    wr_idle = (wr_left == '0);
    // A write needs a quiet bus now, later, and in the cycle before.
    wr_ok = wr_idle && !live_any && !last_rd_beat;
    // The first read beat must come after the last write beat plus a gap.
    rd_ok = !rd_clash && (int'(wr_left) < int'(cl));
    req_ready = req_write ? wr_ok : rd_ok;
    rd_issue  = req_valid && !req_write && rd_ok;
    wr_issue  = req_valid && req_write && wr_ok;
    kill      = cut_read && req_valid && req_write && wr_idle && live_any;
  end

endmodule

// File: rtl/dq_turn_sched.sv
`timescale 1ns/1ps
module dq_turn_sched
  import dq_sched_pkg::*;
#(
  parameter int DW     = 16,
  parameter int MIN_CL = 2,
  parameter int MAX_CL = 3,
  parameter int MAX_BL = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    cfg_cas_lat,
  input  logic [1:0]    cfg_burst,
  input  logic          cfg_cut_read,
  input  logic          req_valid,
  input  logic          req_write,
  output logic          req_ready,
  input  logic [DW-1:0] wr_data,
  output logic          cmd_issue,
  output logic          cmd_write,
  output logic          dq_oe,
  output logic [DW-1:0] dq_out,
  output logic          dqm,
  output logic          rd_valid
);
  localparam int CNT_W = (MAX_BL > 1) ? $clog2(MAX_BL) : 1;

  logic [1:0]       cl_eff;
  logic             rd_issue, wr_issue, kill;
  logic             rd_beat_now, rd_beat_masked, live_any, rd_clash;
  logic [CNT_W-1:0] wr_left;
  logic             wr_busy;
  logic             rd_valid_q;

  assign cl_eff = clamp_cl(cfg_cas_lat, MIN_CL, MAX_CL);

  dq_rd_occupancy #(.MAX_CL(MAX_CL), .MAX_BL(MAX_BL)) u_rd (
    .clk(clk), .rst_n(rst_n), .cl(cl_eff), .bl(cfg_burst),
    .rd_issue(rd_issue), .kill(kill),
    .beat_now(rd_beat_now), .beat_masked(rd_beat_masked),
    .live_any(live_any), .rd_clash(rd_clash)
  );

  dq_wr_beats #(.CNT_W(CNT_W)) u_wr (
    .clk(clk), .rst_n(rst_n), .bl(cfg_burst), .wr_issue(wr_issue),
    .wr_left(wr_left), .wr_busy(wr_busy)
  );

  dq_issue_ctrl #(.CNT_W(CNT_W)) u_ctl (
    .req_valid(req_valid), .req_write(req_write), .cut_read(cfg_cut_read),
    .cl(cl_eff), .wr_left(wr_left), .live_any(live_any), .rd_clash(rd_clash),
    .last_rd_beat(rd_valid_q),
    .req_ready(req_ready), .rd_issue(rd_issue), .wr_issue(wr_issue), .kill(kill)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) rd_valid_q <= 1'b0;
    else        rd_valid_q <= rd_valid;
  end

  assign cmd_issue = rd_issue | wr_issue;
  assign cmd_write = wr_issue;
  assign dq_oe     = wr_issue | wr_busy;
  assign dq_out    = dq_oe ? wr_data : '0;
  assign dqm       = rd_beat_masked;
  assign rd_valid  = rd_beat_now & ~rd_beat_masked;

endmodule

// File: rtl/dq_turn_sched_chk.sv
`timescale 1ns/1ps
module dq_turn_sched_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       dq_oe,
  input logic       rd_valid,
  input logic       dqm,
  input logic       rd_beat_now,
  input logic       rd_issue,
  input logic [1:0] cl_eff
);
  a_r4_no_bus_clash: assert property (@(posedge clk) disable iff (!rst_n)
    !(dq_oe && rd_valid));

  a_r5_gap_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !dq_oe);

  a_r6_gap_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |=> !rd_valid);

  a_r1_cas2_first_beat: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_issue && cl_eff == 2'd2) |-> ##2 rd_beat_now);

  a_r1_cas3_first_beat: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_issue && cl_eff == 2'd3) |-> ##3 rd_beat_now);

  a_r7_mask_on_read_beat: assert property (@(posedge clk) disable iff (!rst_n)
    dqm |-> rd_beat_now);
endmodule

bind dq_turn_sched dq_turn_sched_chk u_chk (
  .clk(clk), .rst_n(rst_n), .dq_oe(dq_oe), .rd_valid(rd_valid), .dqm(dqm),
  .rd_beat_now(rd_beat_now), .rd_issue(rd_issue), .cl_eff(cl_eff)
);

// File: tb/dq_turn_sched_tb_top.sv
`timescale 1ns/1ps
module dq_turn_sched_tb_top;
  localparam int DW   = 16;
  localparam int LOGN = 2048;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    cfg_cas_lat = 2'd2;
  logic [1:0]    cfg_burst = 2'd2;
  logic          cfg_cut_read = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_write = 1'b0;
  logic          req_ready;
  logic [DW-1:0] wr_data = '0;
  logic          cmd_issue, cmd_write, dq_oe, dqm, rd_valid;
  logic [DW-1:0] dq_out;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  int clash = 0;
  bit done = 0;

  bit            oe_l  [LOGN];
  bit            rv_l  [LOGN];
  bit            dqm_l [LOGN];
  bit            iss_l [LOGN];
  bit            rdy_l [LOGN];
  logic [DW-1:0] dq_l  [LOGN];

  always #5 clk = ~clk;

  dq_turn_sched #(.DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_cas_lat(cfg_cas_lat), .cfg_burst(cfg_burst),
    .cfg_cut_read(cfg_cut_read), .req_valid(req_valid), .req_write(req_write),
    .req_ready(req_ready), .wr_data(wr_data), .cmd_issue(cmd_issue),
    .cmd_write(cmd_write), .dq_oe(dq_oe), .dq_out(dq_out), .dqm(dqm),
    .rd_valid(rd_valid)
  );

  function automatic logic [DW-1:0] wd_of(input int c);
    return DW'(c * 7 + 3);
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    #1 wr_data = wd_of(cyc);
  end

  always @(negedge clk) begin
    if (cyc < LOGN) begin
      oe_l[cyc]  = dq_oe;
      rv_l[cyc]  = rd_valid;
      dqm_l[cyc] = dqm;
      iss_l[cyc] = cmd_issue;
      rdy_l[cyc] = req_ready;
      dq_l[cyc]  = dq_out;
    end
    if (rst_n && dq_oe && rd_valid) clash++;
    if (cmd_issue && !(req_valid && req_ready)) clash++;
    if (cmd_issue && (cmd_write !== req_write)) clash++;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  // Offer one request from posedge+1; returns the cycle it issued in.
  task automatic send(input bit w, output int t);
    req_valid = 1'b1;
    req_write = w;
    forever begin
      @(negedge clk);
      if (req_ready) begin
        t = cyc;
        @(posedge clk); #1;
        req_valid = 1'b0;
        return;
      end
      @(posedge clk); #1;
    end
  endtask

  task automatic chk_rd(input string req, input int t, input int cl, input int bl);
    for (int i = 0; i < bl; i++) chk({req, " beat"}, rv_l[t+cl+i], 1);
    chk({req, " before"}, rv_l[t+cl-1], 0);
    chk({req, " after"}, rv_l[t+cl+bl], 0);
  endtask

  task automatic chk_wr(input string req, input int t, input int bl);
    for (int i = 0; i < bl; i++) begin
      chk({req, " oe"}, oe_l[t+i], 1);
      chk({req, " data"}, dq_l[t+i], wd_of(t+i));
    end
    chk({req, " oe after"}, oe_l[t+bl], 0);
    if (t > 0) chk({req, " oe before"}, oe_l[t-1], 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R3 cmd_issue", cmd_issue, 0);
    chk("R3 dq_oe", dq_oe, 0);
    chk("R3 dqm", dqm, 0);
    chk("R3 rd_valid", rd_valid, 0);
    chk("R3 req_ready", req_ready, 1);
    @(posedge clk); #1;
  endtask

  task automatic t_read(input int cl, input logic [1:0] code);
    int t;
    cfg_cas_lat = 2'(cl); cfg_burst = code; cfg_cut_read = 1'b0;
    idle(2);
    send(1'b0, t);
    idle(cl + 12);
    chk_rd("R1 read window", t, cl, 1 << code);
  endtask

  task automatic t_write(input logic [1:0] code);
    int t;
    cfg_burst = code; cfg_cut_read = 1'b0;
    idle(2);
    send(1'b1, t);
    idle(12);
    chk_wr("R2 write burst", t, 1 << code);
  endtask

  task automatic t_rd_then_wr_wait();
    int t, tw;
    cfg_cas_lat = 2'd3; cfg_burst = 2'd2; cfg_cut_read = 1'b0;
    idle(2);
    send(1'b0, t);
    send(1'b1, tw);
    idle(12);
    chk("R5 write issue cycle", tw, t + 8);
    chk("R5 idle cycle", rv_l[t+7] | oe_l[t+7], 0);
    chk("R10 ready low while held", rdy_l[t+7], 0);
    for (int c = t + 1; c < tw; c++) chk("R10 no issue while held", iss_l[c], 0);
    chk_rd("R5 read beats", t, 3, 4);
    chk_wr("R5 write beats", tw, 4);
  endtask

  task automatic t_wr_then_rd();
    int t, tr;
    cfg_cas_lat = 2'd3; cfg_burst = 2'd2; cfg_cut_read = 1'b0;
    idle(2);
    send(1'b1, t);
    send(1'b0, tr);
    idle(14);
    chk("R6 read issue cycle", tr, t + 2);
    chk("R6 gap cycle", rv_l[t+4] | oe_l[t+4], 0);
    chk_wr("R6 write beats", t, 4);
    chk_rd("R6 read beats", tr, 3, 4);
  endtask

  task automatic t_cut();
    int t, tw;
    cfg_cas_lat = 2'd2; cfg_burst = 2'd3; cfg_cut_read = 1'b1;
    idle(2);
    send(1'b0, t);
    idle(3);
    send(1'b1, tw);
    idle(16);
    chk("R7 write issue cycle", tw, t + 5);
    chk("R7 beat 0 valid", rv_l[t+2], 1);
    chk("R7 beat 1 valid", rv_l[t+3], 1);
    chk("R7 no mask before request", dqm_l[t+3], 0);
    for (int c = t + 4; c <= t + 9; c++) begin
      chk("R7 masked beat dqm", dqm_l[c], 1);
      chk("R7 masked beat not valid", rv_l[c], 0);
    end
    chk("R7 mask ends", dqm_l[t+10], 0);
    chk_wr("R7 write beats", tw, 8);
    cfg_cut_read = 1'b0;
  endtask

  task automatic t_rd_rd();
    int t, t2;
    cfg_cas_lat = 2'd2; cfg_burst = 2'd1; cfg_cut_read = 1'b0;
    idle(2);
    send(1'b0, t);
    send(1'b0, t2);
    idle(10);
    chk("R8 second read cycle", t2, t + 2);
    for (int c = t + 2; c <= t + 5; c++) chk("R8 continuous beats", rv_l[c], 1);
    chk("R8 end", rv_l[t+6], 0);
  endtask

  task automatic t_wr_wr();
    int t, t2;
    cfg_burst = 2'd1; cfg_cut_read = 1'b0;
    idle(2);
    send(1'b1, t);
    send(1'b1, t2);
    idle(8);
    chk("R9 second write cycle", t2, t + 2);
    chk_wr("R9 joined bursts", t, 4);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    #1;
    t_reset();
    rst_n = 1'b1;
    idle(1);
    t_reset();
    t_read(2, 2'd2);
    t_read(3, 2'd0);
    t_read(3, 2'd3);
    t_write(2'd2);
    t_write(2'd0);
    t_rd_then_wr_wait();
    t_wr_then_rd();
    t_cut();
    t_rd_rd();
    t_wr_wr();
    idle(4);
    chk("R4 R10 no bus clash or stray issue", clash, 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule